// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block gives software control over a set of general-purpose pins grouped into banks of 32. Each bank shows the same window of word registers: a read-only view of the synchronized pin levels, an output value, a per-pin drive enable and a set of interrupt controls. A pin can be sensed by level or by edge, with a polarity select and a dual-edge option. Hits are held in a sticky status register, gated by a per-pin enable and merged over all banks into a single interrupt line.

Software reaches the registers through a plain write strobe, a byte address and a 32-bit write word. Read data is a combinational function of the address in the same cycle. The port has no handshake, so every access completes in one cycle and no back-pressure exists. Pins are driven as a value/enable pair for an external pad cell.

Top module: `banked_gpio`

## Requirements
- R1: Bank k occupies byte addresses k*0x200 up to k*0x200+0x1FF, and pin p is bit p%32 of bank p/32. Register offsets within a bank are: 0x00 pin levels, 0x04 output value, 0x08 drive enable, 0x0C sense kind (1 = level, 0 = edge), 0x10 dual edge, 0x14 polarity (1 = rising/high, 0 = falling/low), 0x18 interrupt enable (1 = enabled), 0x1C raw status, 0x20 enabled status, 0x24 status clear.
- R2: After reset every register is zero, every drive enable is low and the interrupt line is low.
- R3: A written output value and drive enable appear on pin_out and pin_oe from the following cycle, and both read back unchanged.
- R4: A pin level that is present before clock edge n reads at offset 0x00 after edge n+1, and not before that edge.
- R5: On an edge-sensed pin without dual edge, only the transition selected by polarity sets the status bit. A level present before edge n that forms that transition sets the status at edge n+2.
- R6: With dual edge set on an edge-sensed pin, rising and falling transitions both set status, whatever the polarity bit holds.
- R7: A level-sensed pin sets its status while its active level is present. A clear has no effect while the level stays active, and the status stays set after the level goes away until it is cleared.
- R8: Offset 0x20 reads raw status AND enable. The interrupt line is high exactly when some enabled status bit in some bank is set.
- R9: Writing 1 to a bit at offset 0x24 clears that status bit, writing 0 leaves it unchanged, and offset 0x24 reads as zero.
- R10: When a status-setting hit and a clear of the same bit fall in the same cycle, the bit ends up set.
- R11: Offsets not in the list of R1 read as zero. Writes to the pin-level, raw-status and enabled-status offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (10) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NUM_BANKS*32 | Raw pin levels, asynchronous |
| pin_out | output | NUM_BANKS*32 | Output value per pin |
| pin_oe | output | NUM_BANKS*32 | Drive enable per pin |
| irq | output | 1 | Merged interrupt request |

## Verification
The hardest case to reach from the ports is a hit and a clear that land on the same clock edge. The pin change has to pass two synchronizer stages and the previous-value stage, so the bench raises the pin, waits exactly one falling edge and then issues the clear write. The write is then present at the edge where the hit is registered. A second hard area is the order of configuration writes. Setting the sense kind to level before the polarity would turn a quiet low pin into an active-low hit. The bench writes the polarity first and checks that the status stays clear, and a cycle-accurate reference model catches any stray status bit on every clock.

// File: rtl/gpioc_pkg.sv
package gpioc_pkg;
  localparam int unsigned BANK_PINS = 32;
  localparam int unsigned OFF_W     = 9;   // byte offset inside a 0x200 bank window

  localparam logic [OFF_W-1:0] OFF_LVL  = 9'h000;
  localparam logic [OFF_W-1:0] OFF_OUT  = 9'h004;
  localparam logic [OFF_W-1:0] OFF_DRV  = 9'h008;
  localparam logic [OFF_W-1:0] OFF_KIND = 9'h00C;
  localparam logic [OFF_W-1:0] OFF_BOTH = 9'h010;
  localparam logic [OFF_W-1:0] OFF_POL  = 9'h014;
  localparam logic [OFF_W-1:0] OFF_EN   = 9'h018;
  localparam logic [OFF_W-1:0] OFF_RAW  = 9'h01C;
  localparam logic [OFF_W-1:0] OFF_MSK  = 9'h020;
  localparam logic [OFF_W-1:0] OFF_CLR  = 9'h024;
endpackage

// File: rtl/gpioc_sync.sv
module gpioc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] smp_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, smp_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      smp_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      smp_q  <= meta_q;
      prev_q <= smp_q;
    end
  end

  assign smp_o  = smp_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpioc_sense.sv
module gpioc_sense #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] kind_i,   // 1 = level
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, set_vec, status_q;

  assign rise     = smp_i & ~prev_i;
  assign fall     = ~smp_i & prev_i;
  assign edge_hit = (both_i & (rise | fall))
                  | (~both_i & pol_i & rise)
                  | (~both_i & ~pol_i & fall);
  assign lvl_hit  = (pol_i & smp_i) | (~pol_i & ~smp_i);
  assign set_vec  = (kind_i & lvl_hit) | (~kind_i & edge_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= set_vec | (status_q & ~clr_i);
  end

  assign status_o = status_q;

  // R5
  new_bit_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

  // R9
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_vec) != '0) |=> ((status_q & $past(clr_i & ~set_vec)) == '0));

  // R10
  hit_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & set_vec) != '0) |=> ((status_q & $past(clr_i & set_vec)) == $past(clr_i & set_vec)));
endmodule

// File: rtl/gpioc_bank.sv
module gpioc_bank
  import gpioc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [OFF_W-1:0]     off_i,
  input  logic [BANK_PINS-1:0] wdata_i,
  input  logic [BANK_PINS-1:0] pin_i,
  output logic [BANK_PINS-1:0] rdata_o,
  output logic [BANK_PINS-1:0] out_o,
  output logic [BANK_PINS-1:0] drv_o,
  output logic                 irq_o,
  output logic                 en_any_o
);
  logic [BANK_PINS-1:0] out_q, drv_q, kind_q, both_q, pol_q, en_q;
  logic [BANK_PINS-1:0] smp, prev, clr, raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      drv_q  <= '0;
      kind_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else if (wr_i) begin
      case (off_i)
        OFF_OUT:  out_q  <= wdata_i;
        OFF_DRV:  drv_q  <= wdata_i;
        OFF_KIND: kind_q <= wdata_i;
        OFF_BOTH: both_q <= wdata_i;
        OFF_POL:  pol_q  <= wdata_i;
        OFF_EN:   en_q   <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr = (wr_i && off_i == OFF_CLR) ? wdata_i : '0;

  gpioc_sync #(.W(BANK_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .smp_o   (smp),
    .prev_o  (prev)
  );

  gpioc_sense #(.W(BANK_PINS)) u_sense (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind_q),
    .both_i   (both_q),
    .pol_i    (pol_q),
    .smp_i    (smp),
    .prev_i   (prev),
    .clr_i    (clr),
    .status_o (raw)
  );

  always_comb begin
    case (off_i)
      OFF_LVL:  rdata_o = smp;
      OFF_OUT:  rdata_o = out_q;
      OFF_DRV:  rdata_o = drv_q;
      OFF_KIND: rdata_o = kind_q;
      OFF_BOTH: rdata_o = both_q;
      OFF_POL:  rdata_o = pol_q;
      OFF_EN:   rdata_o = en_q;
      OFF_RAW:  rdata_o = raw;
      OFF_MSK:  rdata_o = raw & en_q;
      default:  rdata_o = '0;
    endcase
  end

  assign out_o    = out_q;
  assign drv_o    = drv_q;
  assign irq_o    = |(raw & en_q);
  assign en_any_o = |en_q;

  // R9
  clear_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i == OFF_CLR) |-> (rdata_o == '0));

  // R3
  drive_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && off_i == OFF_DRV) |=> $stable(drv_o));
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
  import gpioc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NPINS    = NUM_BANKS * BANK_PINS,
  localparam int unsigned BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ADDR_W   = OFF_W + BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [BSEL_W-1:0]    bank_sel;
  logic [OFF_W-1:0]     bank_off;
  logic [31:0]          rd_arr [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_vec, en_vec;

  assign bank_sel = bus_addr[ADDR_W-1:OFF_W];
  assign bank_off = bus_addr[OFF_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpioc_bank u_bank (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .wr_i     (bus_we && bank_sel == BSEL_W'(b)),
      .off_i    (bank_off),
      .wdata_i  (bus_wdata),
      .pin_i    (pin_in[b*BANK_PINS +: BANK_PINS]),
      .rdata_o  (rd_arr[b]),
      .out_o    (pin_out[b*BANK_PINS +: BANK_PINS]),
      .drv_o    (pin_oe[b*BANK_PINS +: BANK_PINS]),
      .irq_o    (irq_vec[b]),
      .en_any_o (en_vec[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel == BSEL_W'(b)) bus_rdata = rd_arr[b];
  end

  assign irq = |irq_vec;

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|en_vec));

  // R2
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && pin_oe == '0));
endmodule

// File: tb/banked_gpio_bench.sv
module banked_gpio_bench;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          drv_we = 1'b0;
  logic [9:0]    drv_addr = '0;
  logic [31:0]   drv_wdata = '0;
  logic [NP-1:0] drv_pin = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  banked_gpio u_banked_gpio (
    .clk(clk), .rst_n(rst_n), .bus_we(drv_we), .bus_addr(drv_addr),
    .bus_wdata(drv_wdata), .bus_rdata(bus_rdata), .pin_in(drv_pin),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_out [NB], m_drv [NB], m_kind [NB], m_both [NB];
  logic [31:0] m_pol [NB], m_en [NB], m_st [NB];
  logic [NP-1:0] m_meta, m_smp, m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_out[b] = 0; m_drv[b] = 0; m_kind[b] = 0; m_both[b] = 0;
        m_pol[b] = 0; m_en[b] = 0; m_st[b] = 0;
      end
      m_meta = '0; m_smp = '0; m_prev = '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        logic [31:0] nst;
        int off;
        bit this_bank;
        this_bank = drv_we && (int'(drv_addr) / 512 == b);
        off = int'(drv_addr) % 512;
        for (int i = 0; i < 32; i++) begin
          bit cur, old, hit, clr;
          cur = m_smp[b*32+i];
          old = m_prev[b*32+i];
          if (m_kind[b][i])      hit = m_pol[b][i] ? cur : !cur;
          else if (m_both[b][i]) hit = (cur != old);
          else if (m_pol[b][i])  hit = cur && !old;
          else                   hit = !cur && old;
          clr = this_bank && off == 'h24 && drv_wdata[i];
          if (hit)      nst[i] = 1'b1;
          else if (clr) nst[i] = 1'b0;
          else          nst[i] = m_st[b][i];
        end
        m_st[b] = nst;
        if (this_bank) begin
          case (off)
            'h04: m_out[b]  = drv_wdata;
            'h08: m_drv[b]  = drv_wdata;
            'h0C: m_kind[b] = drv_wdata;
            'h10: m_both[b] = drv_wdata;
            'h14: m_pol[b]  = drv_wdata;
            'h18: m_en[b]   = drv_wdata;
            default: ;
          endcase
        end
      end
      m_prev = m_smp;
      m_smp  = m_meta;
      m_meta = drv_pin;
    end
  end

  function automatic logic [31:0] model_read(input logic [9:0] a);
    int b, off;
    b = int'(a) / 512;
    off = int'(a) % 512;
    case (off)
      'h00: return m_smp[b*32 +: 32];
      'h04: return m_out[b];
      'h08: return m_drv[b];
      'h0C: return m_kind[b];
      'h10: return m_both[b];
      'h14: return m_pol[b];
      'h18: return m_en[b];
      'h1C: return m_st[b];
      'h20: return m_st[b] & m_en[b];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic model_irq();
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r |= |(m_st[b] & m_en[b]);
    return r;
  endfunction

  function automatic logic [NP-1:0] cat_regs(input bit want_drv);
    logic [NP-1:0] v;
    for (int b = 0; b < NB; b++) v[b*32 +: 32] = want_drv ? m_drv[b] : m_out[b];
    return v;
  endfunction

  // per-clock comparison, away from both edges
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      vectors++;
      if (bus_rdata !== model_read(drv_addr)) begin
        misses++;
        $display("FAIL R1 model read @%h act=%h exp=%h", drv_addr, bus_rdata, model_read(drv_addr));
      end
      vectors++;
      if (irq !== model_irq()) begin
        misses++;
        $display("FAIL R8 model irq act=%b exp=%b", irq, model_irq());
      end
      vectors++;
      if (pin_oe !== cat_regs(1) || pin_out !== cat_regs(0)) begin
        misses++;
        $display("FAIL R3 model pins act=%h/%h exp=%h/%h", pin_oe, pin_out, cat_regs(1), cat_regs(0));
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    drv_we = 1'b1; drv_addr = a; drv_wdata = d;
    @(negedge clk);
    drv_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    drv_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic setpin(input int idx, input logic v);
    @(negedge clk);
    drv_pin[idx] = v;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      misses++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    ticks(5);
    rst_n = 1'b1;

    rd('h008, v); chk("R2 drive enable after reset", v, 0);
    rd('h01C, v); chk("R2 status after reset", v, 0);
    chk("R2 irq after reset", {31'd0, irq}, 0);
    chk("R2 pin_oe after reset", pin_oe[31:0], 0);

    wr('h004, 32'hA5A5_0000);
    wr('h008, 32'hFFFF_0000);
    chk("R3 pin_oe", pin_oe[31:0], 32'hFFFF_0000);
    chk("R3 pin_out", pin_out[31:0], 32'hA5A5_0000);
    rd('h008, v); chk("R3 drive readback", v, 32'hFFFF_0000);

    wr('h208, 32'h1);
    chk("R1 bank1 pin32 drive", {30'd0, pin_oe[33:32]}, 32'h1);
    rd('h008, v); chk("R1 bank0 untouched", v, 32'hFFFF_0000);

    @(negedge clk); drv_pin[31:0] = 32'h1234;
    rd('h000, v); chk("R4 level one edge later", v, 0);
    rd('h000, v); chk("R4 level two edges later", v, 32'h1234);
    wr('h000, 32'hFFFF_FFFF);
    rd('h000, v); chk("R11 level write ignored", v, 32'h1234);

    @(negedge clk); drv_pin = '0;
    ticks(4);
    wr('h024, 32'hFFFF_FFFF);
    rd('h01C, v); chk("R9 clear all", v, 0);

    wr('h014, 32'h9);   // polarity before kind
    wr('h010, 32'h4);
    wr('h018, 32'hB);
    wr('h00C, 32'h8);
    rd('h01C, v); chk("R7 no stray hit from config order", v, 0);

    setpin(0, 1);
    rd('h01C, v); chk("R5 rise not yet (n+1)", v, 0);
    rd('h01C, v); chk("R5 rise not yet (n+2)", v, 0);
    rd('h01C, v); chk("R5 rise latched", v, 32'h1);
    chk("R8 irq on enabled hit", {31'd0, irq}, 1);
    rd('h020, v); chk("R8 enabled status", v, 32'h1);

    wr('h024, 32'h0);
    rd('h01C, v); chk("R9 zero write no effect", v, 32'h1);
    wr('h024, 32'h1);
    rd('h01C, v); chk("R9 one write clears", v, 0);
    chk("R9 irq drops", {31'd0, irq}, 0);
    rd('h024, v); chk("R9 clear reads zero", v, 0);

    setpin(0, 0); ticks(4);
    rd('h01C, v); chk("R5 falling ignored on rising pin", v, 0);
    setpin(1, 1); ticks(4);
    rd('h01C, v); chk("R5 rising ignored on falling pin", v, 0);
    setpin(1, 0); ticks(4);
    rd('h01C, v); chk("R5 falling latched", v, 32'h2);
    wr('h024, 32'h2);

    setpin(2, 1); ticks(4);
    rd('h01C, v); chk("R6 dual edge rise", v, 32'h4);
    rd('h020, v); chk("R8 disabled bit hidden", v, 0);
    chk("R8 irq low for disabled bit", {31'd0, irq}, 0);
    wr('h024, 32'h4);
    setpin(2, 0); ticks(4);
    rd('h01C, v); chk("R6 dual edge fall", v, 32'h4);
    wr('h024, 32'h4);

    setpin(3, 1); ticks(4);
    rd('h01C, v); chk("R7 level active", v, 32'h8);
    chk("R7 irq", {31'd0, irq}, 1);
    wr('h024, 32'h8);
    rd('h01C, v); chk("R7 clear ignored while active", v, 32'h8);
    setpin(3, 0); ticks(4);
    rd('h01C, v); chk("R7 sticky after level gone", v, 32'h8);
    wr('h024, 32'h8);
    rd('h01C, v); chk("R7 clear after inactive", v, 0);

    wr('h214, 32'h100);
    wr('h218, 32'h100);
    setpin(40, 1); ticks(4);
    rd('h21C, v); chk("R8 bank1 raw", v, 32'h100);
    chk("R8 irq from bank1", {31'd0, irq}, 1);
    rd('h220, v); chk("R8 bank1 enabled status", v, 32'h100);
    wr('h224, 32'h100);
    chk("R8 irq after bank1 clear", {31'd0, irq}, 0);

    setpin(0, 1);
    ticks(1);
    wr('h024, 32'h1);   // write present on the edge that latches the hit
    rd('h01C, v); chk("R10 hit wins over clear", v, 32'h1);
    wr('h024, 32'h1);
    rd('h01C, v); chk("R10 later clear works", v, 0);

    rd('h028, v); chk("R11 unmapped 0x28", v, 0);
    rd('h1FC, v); chk("R11 unmapped 0x1FC", v, 0);
    rd('h230, v); chk("R11 unmapped bank1 0x30", v, 0);
    setpin(0, 0); setpin(0, 1); ticks(4);
    wr('h01C, 32'h0);
    rd('h01C, v); chk("R11 raw status write ignored", v, 32'h1);
    wr('h020, 32'h0);
    rd('h020, v); chk("R11 enabled status write ignored", v, 32'h1);

    ticks(3);
    finish_run();
  end
endmodule